// File: doc/BRIEF.md
# Approximate Value Mask Generator

This unit sits in front of a pattern-matching compressor on the sending side of a network interface. For every data word it produces two things: a normalized 32-bit value and a mask of low-order bits that a downstream matcher may treat as don't-care. Any word that agrees with the normalized value on every bit outside the mask lies within a programmed error bound of that value. This lets the compressor accept a near match to a stored pattern instead of requiring an exact one.

The error bound is the normalized value shifted right by a programmed amount, so no multiplier or divider is needed. A single-precision float is first reduced to its 24-bit significand: the stored fraction with the hidden one restored, and the exponent left out. Floats then pass through the same masking path as integers. Words marked as not approximable, and floats whose exponent field is all zeros or all ones, pass through untouched with an empty mask. Words enter and leave on a valid/ready stream with one register stage between them.

Top module: `approx_mask_unit`

## Requirements
- R1: After a synchronous active-low reset, `res_valid` is low, `word_ready` is high and the held shift amount is zero, so a word sent before any configuration leaves with a zero mask.
- R2: A word with `word_approx` low leaves with `res_value` equal to the input word and `res_mask` zero, for either data type.
- R3: For an approximable integer word v with shift s in 1..31, the range is r = v >> s, and `res_mask` has its k low bits set and the rest clear, where k is the largest integer with 2^k - 1 <= r. `res_value` equals v.
- R4: For an approximable float word (`word_is_float` high) whose exponent field, bits 30..23, is neither 0x00 nor 0xFF, `res_value` is {8'h00, 1'b1, bits 22..0}. The mask follows the rule of R3, applied to that value.
- R5: A float word whose exponent field is 0x00 or 0xFF leaves with `res_value` equal to the input word and `res_mask` zero, even when approximable.
- R6: A shift amount of zero, or a range of zero, gives `res_mask` zero.
- R7: For float words, `res_mask` bits 31..23 are always zero.
- R8: `cfg_load` updates the held shift amount from `cfg_shift` only in a cycle where `res_valid` and `word_valid` are both low. In any other cycle it is ignored, and words still use the previous amount.
- R9: `word_ready` equals `!res_valid || res_ready`. A word accepted on a clock edge appears on `res_valid`, `res_value` and `res_mask` right after that edge. While `res_valid` is high and `res_ready` is low, the outputs stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Request to load a new shift amount |
| cfg_shift | input | 5 | Right-shift amount that sets the error bound |
| word_valid | input | 1 | Input word present |
| word_ready | output | 1 | Unit can accept a word |
| word_data | input | 32 | Input data word |
| word_is_float | input | 1 | 1: single-precision float, 0: integer |
| word_approx | input | 1 | 1: word may be approximated |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Downstream accepts the result |
| res_value | output | 32 | Normalized value |
| res_mask | output | 32 | Don't-care bit mask |

## Verification
The vector table covers integer words whose ranges land just above and just below a power-of-two boundary, an all-ones word that yields the widest mask, and the largest shift, which leaves a range of one. Float cases include normal numbers of both signs, and a significand of all ones that reaches the bit-22 ceiling. They also include zero, a denormal and infinity, which separate the exponent bypass from ordinary masking. Non-approximable words of both types confirm raw passthrough. Directed tests stall the output and try to reload the shift while the unit is busy. The next word's mask then shows whether the old amount was kept.

// File: rtl/approx_pkg.sv
package approx_pkg;
    localparam int DATA_W  = 32;
    localparam int MANT_W  = 23;
    localparam int EXP_W   = 8;
    localparam int SHIFT_W = 5;
    localparam int EXP_LSB = MANT_W;
    localparam int EXP_MSB = MANT_W + EXP_W - 1;
    localparam int SIG_W   = MANT_W + 1;

    typedef struct packed {
        logic              valid;
        logic [SHIFT_W-1:0] shift;
        logic [DATA_W-1:0]  value;
        logic [DATA_W-1:0]  mask;
    } stage_t;
endpackage

// File: rtl/approx_normalize.sv
module approx_normalize
    import approx_pkg::*;
(
    input  logic [DATA_W-1:0] raw,
    input  logic              is_float,
    input  logic              approx,
    output logic [DATA_W-1:0] norm,
    output logic              bypass
);
    logic [EXP_W-1:0] exp_f;
    logic             exp_special;

    always_comb begin
        exp_f       = raw[EXP_MSB:EXP_LSB];
        exp_special = (exp_f == '0) || (exp_f == '1);
        bypass      = !approx || (is_float && exp_special);
        if (bypass || !is_float)
            norm = raw;
        else
            norm = {{(DATA_W-SIG_W){1'b0}}, 1'b1, raw[MANT_W-1:0]};
    end
endmodule

// File: rtl/approx_range_mask.sv
module approx_range_mask
    import approx_pkg::*;
(
    input  logic [DATA_W-1:0]  value,
    input  logic [SHIFT_W-1:0] shift,
    input  logic               is_float,
    input  logic               bypass,
    output logic [DATA_W-1:0]  mask
);
    localparam logic [DATA_W-1:0] FLOAT_LIMIT = DATA_W'((64'd1 << MANT_W) - 64'd1);

    logic [DATA_W-1:0] err_range;
    logic [DATA_W-1:0] raw_mask;

    always_comb begin
        if (shift == '0)
            err_range = '0;
        else
            err_range = value >> shift;
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam logic [DATA_W:0] THR = (DATA_W+1)'((65'd1 << (i + 1)) - 65'd1);
        assign raw_mask[i] = ({1'b0, err_range} >= THR);
    end

    always_comb begin
        if (bypass)
            mask = '0;
        else if (is_float)
            mask = raw_mask & FLOAT_LIMIT;
        else
            mask = raw_mask;
    end
endmodule

// File: rtl/approx_mask_unit.sv
module approx_mask_unit
    import approx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_load,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic               word_valid,
    output logic               word_ready,
    input  logic [DATA_W-1:0]  word_data,
    input  logic               word_is_float,
    input  logic               word_approx,
    output logic               res_valid,
    input  logic               res_ready,
    output logic [DATA_W-1:0]  res_value,
    output logic [DATA_W-1:0]  res_mask
);
    stage_t st_d, st_q;

    logic [DATA_W-1:0] norm_w;
    logic              bypass_w;
    logic [DATA_W-1:0] mask_w;
    logic              idle_w;
    logic              accept_w;

    approx_normalize u_norm (
        .raw      (word_data),
        .is_float (word_is_float),
        .approx   (word_approx),
        .norm     (norm_w),
        .bypass   (bypass_w)
    );

    approx_range_mask u_mask (
        .value    (norm_w),
        .shift    (st_q.shift),
        .is_float (word_is_float),
        .bypass   (bypass_w),
        .mask     (mask_w)
    );

    always_comb begin
        word_ready = !st_q.valid || res_ready;
        accept_w   = word_valid && word_ready;
        idle_w     = !st_q.valid && !word_valid;
        st_d       = st_q;
        if (cfg_load && idle_w)
            st_d.shift = cfg_shift;
        if (accept_w) begin
            st_d.valid = 1'b1;
            st_d.value = norm_w;
            st_d.mask  = mask_w;
        end else if (res_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign res_valid = st_q.valid;
    assign res_value = st_q.value;
    assign res_mask  = st_q.mask;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_value) && $stable(res_mask));

    // R2
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && word_ready && !word_approx |=> res_mask == '0 && res_value == $past(word_data));

    // R7
    float_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && word_ready && word_is_float |=> res_mask[DATA_W-1:MANT_W] == '0);

    // R6
    zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && word_ready && st_q.shift == '0 |=> res_mask == '0);

    // R3
    mask_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_mask + 1'b1) & res_mask) == '0);

    // R8
    cfg_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load && (res_valid || word_valid) |=> st_q.shift == $past(st_q.shift));
endmodule

// File: tb/approx_mask_unit_test.sv
`timescale 1ns/1ps
module approx_mask_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_load;
    logic [4:0]  cfg_shift;
    logic        word_valid;
    logic        word_ready;
    logic [31:0] word_data;
    logic        word_is_float;
    logic        word_approx;
    logic        res_valid;
    logic        res_ready;
    logic [31:0] res_value;
    logic [31:0] res_mask;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    approx_mask_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_shift(cfg_shift),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
        .word_is_float(word_is_float), .word_approx(word_approx),
        .res_valid(res_valid), .res_ready(res_ready),
        .res_value(res_value), .res_mask(res_mask)
    );

    // {shift, is_float, approx, data, expected value, expected mask}
    localparam int NV = 14;
    localparam logic [102:0] VEC [NV] = '{
        {5'd2,  1'b0, 1'b1, 32'h0000_0080, 32'h0000_0080, 32'h0000_001F}, // R3
        {5'd1,  1'b0, 1'b1, 32'h0000_0009, 32'h0000_0009, 32'h0000_0003}, // R3
        {5'd0,  1'b0, 1'b1, 32'h0000_1000, 32'h0000_1000, 32'h0000_0000}, // R6
        {5'd3,  1'b0, 1'b1, 32'h0000_0007, 32'h0000_0007, 32'h0000_0000}, // R6
        {5'd1,  1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF}, // R3
        {5'd4,  1'b0, 1'b0, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000}, // R2
        {5'd1,  1'b1, 1'b1, 32'h3F80_0000, 32'h0080_0000, 32'h003F_FFFF}, // R4
        {5'd2,  1'b1, 1'b1, 32'hC049_0FDB, 32'h00C9_0FDB, 32'h001F_FFFF}, // R4
        {5'd1,  1'b1, 1'b1, 32'h7F80_0000, 32'h7F80_0000, 32'h0000_0000}, // R5
        {5'd1,  1'b1, 1'b1, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000}, // R5
        {5'd1,  1'b1, 1'b0, 32'h3F80_0000, 32'h3F80_0000, 32'h0000_0000}, // R2
        {5'd31, 1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, 32'h0000_0001}, // R3
        {5'd1,  1'b1, 1'b1, 32'h3FFF_FFFF, 32'h00FF_FFFF, 32'h007F_FFFF}, // R7
        {5'd3,  1'b1, 1'b1, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000}  // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_shift(input logic [4:0] s);
        cfg_load  = 1'b1;
        cfg_shift = s;
        tick();
        cfg_load  = 1'b0;
    endtask

    task automatic send(input logic fl, input logic ap, input logic [31:0] d);
        word_valid    = 1'b1;
        word_is_float = fl;
        word_approx   = ap;
        word_data     = d;
        tick();
        word_valid    = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_load = 1'b0; cfg_shift = '0; word_valid = 1'b0;
        word_data = '0; word_is_float = 1'b0; word_approx = 1'b0; res_ready = 1'b1;
        #2;
        tick(); tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 res_valid", {31'd0, res_valid}, 32'd0);
        check("R1 word_ready", {31'd0, word_ready}, 32'd1);
        send(1'b0, 1'b1, 32'h0000_0100);
        check("R1 shift zero mask", res_mask, 32'd0);
        check("R9 latency valid", {31'd0, res_valid}, 32'd1);
        tick();

        for (int i = 0; i < NV; i++) begin
            load_shift(VEC[i][102:98]);
            send(VEC[i][97], VEC[i][96], VEC[i][95:64]);
            check($sformatf("R3/R4 vec%0d value", i), res_value, VEC[i][63:32]);
            check($sformatf("R3/R4 vec%0d mask", i), res_mask, VEC[i][31:0]);
            tick();
        end

        // R9 stall and R8 ignored load while busy
        load_shift(5'd1);
        res_ready = 1'b0;
        send(1'b0, 1'b1, 32'h0000_0009);
        check("R9 stall ready low", {31'd0, word_ready}, 32'd0);
        cfg_load = 1'b1; cfg_shift = 5'd5;
        tick();
        cfg_load = 1'b0;
        check("R9 stall valid held", {31'd0, res_valid}, 32'd1);
        check("R9 stall mask held", res_mask, 32'h3);
        check("R9 ready follows res_ready", {31'd0, word_ready}, 32'd0);
        res_ready = 1'b1;
        #1;
        check("R9 ready with res_ready", {31'd0, word_ready}, 32'd1);
        tick();
        check("R9 drained", {31'd0, res_valid}, 32'd0);
        send(1'b0, 1'b1, 32'h0000_0009);
        check("R8 busy load ignored", res_mask, 32'h3);
        tick();

        // R8 load accepted while idle
        load_shift(5'd5);
        send(1'b0, 1'b1, 32'h0000_0009);
        check("R8 idle load taken", res_mask, 32'h0);
        tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule